// File: doc/BRIEF.md
# Half-Approximate Parallel-Carry Adder

This block adds two unsigned operands of `WIDTH` bits and returns a `WIDTH+1`-bit result. It trades exactness for speed and energy, which suits datapaths that tolerate small errors, such as pixel arithmetic. The result is split at the midpoint `H = WIDTH/2`. The lower `H` result bits come from a bitwise OR of the operand bits, so no carry chain runs through that half. The upper `H` bits and the carry-out are formed exactly by a chain of 4-bit sub-adders. Inside each sub-adder every carry is computed at once from generate and propagate terms instead of rippling through the bits. Only the group carry-out passes from one 4-bit block to the next.

The parameter `RECOVER` picks one of two variants. In the plain variant the exact half starts with a carry-in of zero. In the recovery variant the carry-in is the AND of the two operand bits at position `H-1`. When that carry is 1, every low result bit below `H-1` is set to 1. This pulls the approximate low half toward the true value and lowers the mean error. In both variants the absolute error never exceeds `2^H`.

The parameter `REGISTERED` adds one register stage on the operands and one on the result. Both stages use a synchronous active-low reset.

Top module: `hapc_adder`

## Requirements
- R1: `WIDTH` must be a non-zero multiple of 8, so that each half divides evenly into 4-bit blocks. Any other value stops elaboration with an error.
- R2: Each result bit `i` with `i < H` equals `op_a[i] | op_b[i]`, unless R6 forces it. No carry leaves the low half except the one defined in R5.
- R3: Result bits `WIDTH:H` equal `op_a[WIDTH-1:H] + op_b[WIDTH-1:H] + cin`. Here `cin` is the carry into the exact half, and result bit `WIDTH` is the carry-out of the top 4-bit block.
- R4: A carry produced in one 4-bit block reaches the next block above it. For example, upper halves of 0x0F and 0x01 give an upper result of 0x10.
- R5: `cin` is 0 when `RECOVER=0`. When `RECOVER=1`, `cin` equals `op_a[H-1] & op_b[H-1]`.
- R6: When `RECOVER=1` and `cin` is 1, result bits `H-2:0` are all 1. Result bit `H-1` keeps its OR value from R2.
- R7: For every operand pair, the absolute difference between the result and the exact sum `op_a + op_b` is at most `2^H`.
- R8: Over one shared set of uniformly random operands, the mean absolute error of the recovery variant is lower than the mean absolute error of the plain variant.
- R9: With `REGISTERED=1`, operands are sampled at one rising clock edge and their result appears on `sum` after the next rising edge. While `rst_n` is low at a rising edge, both stages clear, and `sum` reads 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional register stages |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | WIDTH | First unsigned operand |
| op_b | input | WIDTH | Second unsigned operand |
| sum | output | WIDTH+1 | Approximate sum; the MSB is the carry-out of the exact half |

## Verification
A stuck or wrong lookahead term inside a 4-bit block shows up at once in the upper result bits. It appears on the first vector whose bits in that block exercise the term, two clocks after the operands are applied. The directed vectors that carry across blocks and out of the top expose a broken chain link on a single vector. A fault in the recovery carry or in the low-half fill only shows when both operand bits at position `H-1` are 1. A quarter of the random vectors meet that condition, so such a fault is caught within the first few vectors. A shift in the mean error shows up only in the comparison of averages at the end of the run.

// File: rtl/hapc_pkg.sv
// Package: hapc_pkg
// Purpose: constants and helpers shared by the half-approximate adder.
// Assumes: the operand width is split in half, and each half is a whole
//          number of 4-bit lookahead blocks.
package hapc_pkg;

    // Bits per parallel-carry block.
    localparam int BLK_BITS = 4;

    // Returns 1 when the width can be split into two halves of whole blocks.
    function automatic bit width_ok(input int w);
        return (w >= 2 * BLK_BITS) && ((w % (2 * BLK_BITS)) == 0);
    endfunction

    // Returns the number of 4-bit blocks needed to cover a half of width w.
    function automatic int half_blocks(input int w);
        return (w / 2) / BLK_BITS;
    endfunction

endpackage

// File: rtl/hapc_cla4.sv
// Module: hapc_cla4
// Purpose: exact 4-bit adder. All internal carries are formed at once from
//          per-bit generate/propagate terms, with no ripple between bits.
// Assumes: purely combinational; the caller chains the group carry-out.
module hapc_cla4 (
    input  logic [3:0] blk_a,
    input  logic [3:0] blk_b,
    input  logic       blk_ci,
    output logic [3:0] blk_s,
    output logic       blk_co
);

    logic [3:0] gen;
    logic [3:0] prp;
    logic [4:0] cy;

    // Per-bit generate and propagate terms.
    always_comb begin
        gen = blk_a & blk_b;
        prp = blk_a ^ blk_b;
    end

    // Two-level lookahead: every carry is a flat sum of products.
    always_comb begin
        cy[0] = blk_ci;
        cy[1] = gen[0] | (prp[0] & blk_ci);
        cy[2] = gen[1] | (prp[1] & gen[0]) | (prp[1] & prp[0] & blk_ci);
        cy[3] = gen[2] | (prp[2] & gen[1]) | (prp[2] & prp[1] & gen[0])
              | (prp[2] & prp[1] & prp[0] & blk_ci);
        cy[4] = gen[3] | (prp[3] & gen[2]) | (prp[3] & prp[2] & gen[1])
              | (prp[3] & prp[2] & prp[1] & gen[0])
              | (prp[3] & prp[2] & prp[1] & prp[0] & blk_ci);
    end

    // Sum bits and the group carry-out.
    always_comb begin
        blk_s  = prp ^ cy[3:0];
        blk_co = cy[4];
    end

    // Block result must equal the arithmetic sum of its inputs.
    always_comb begin
        if (!$isunknown({blk_a, blk_b, blk_ci})) begin
            AST_BLOCK_SUM: assert ({blk_co, blk_s} == ({1'b0, blk_a} + {1'b0, blk_b} + {4'b0, blk_ci})); // R4
        end
    end

endmodule

// File: rtl/hapc_exact_high.sv
// Module: hapc_exact_high
// Purpose: exact adder for the upper half, built as a chain of 4-bit
//          parallel-carry blocks. Each block's group carry-out feeds the
//          carry-in of the block above.
// Assumes: HALF is a multiple of 4 (the top module checks this).
module hapc_exact_high #(
    parameter int HALF = 8
) (
    input  logic [HALF-1:0] hi_a,
    input  logic [HALF-1:0] hi_b,
    input  logic            hi_ci,
    output logic [HALF:0]   hi_sum
);

    import hapc_pkg::*;

    localparam int NBLK = HALF / BLK_BITS;

    logic [NBLK:0]   link;
    logic [HALF-1:0] part;

    // The chain starts at the carry into the exact half.
    always_comb link[0] = hi_ci;

    for (genvar k = 0; k < NBLK; k++) begin : g_blk
        hapc_cla4 u_blk (
            .blk_a  (hi_a[k*BLK_BITS +: BLK_BITS]),
            .blk_b  (hi_b[k*BLK_BITS +: BLK_BITS]),
            .blk_ci (link[k]),
            .blk_s  (part[k*BLK_BITS +: BLK_BITS]),
            .blk_co (link[k+1])
        );
    end

    // Put the top carry-out above the block sums.
    always_comb hi_sum = {link[NBLK], part};

endmodule

// File: rtl/hapc_or_low.sv
// Module: hapc_or_low
// Purpose: carry-free approximate lower half. Each bit is an OR of the
//          operand bits. With RECOVER set, the top-bit AND becomes the carry
//          into the exact half, and when it is 1 the lower bits are filled
//          with ones.
// Assumes: HALF >= 4; purely combinational.
module hapc_or_low #(
    parameter int HALF    = 8,
    parameter bit RECOVER = 1'b0
) (
    input  logic [HALF-1:0] lo_a,
    input  logic [HALF-1:0] lo_b,
    output logic [HALF-1:0] lo_sum,
    output logic            lo_cy
);

    logic [HALF-1:0] ored;

    // Bitwise OR approximation, no carry between bits.
    always_comb ored = lo_a | lo_b;

    if (RECOVER) begin : g_rec
        // Recovery: take the top-bit carry and fill the bits below it.
        always_comb begin
            lo_cy  = lo_a[HALF-1] & lo_b[HALF-1];
            lo_sum = {ored[HALF-1], ored[HALF-2:0] | {(HALF-1){lo_cy}}};
        end
    end else begin : g_plain
        // Plain: no carry leaves the approximate half.
        always_comb begin
            lo_cy  = 1'b0;
            lo_sum = ored;
        end
    end

endmodule

// File: rtl/hapc_adder.sv
// Module: hapc_adder
// Purpose: top of the half-approximate adder. The lower half is an OR
//          approximation, the upper half is exact with parallel-carry blocks.
//          Optional register stages on the operands and on the result.
// Assumes: unsigned operands; WIDTH a multiple of 8; synchronous active-low
//          reset, used only when REGISTERED is set.
module hapc_adder #(
    parameter int WIDTH      = 16,
    parameter bit RECOVER    = 1'b0,
    parameter bit REGISTERED = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH:0]   sum
);

    import hapc_pkg::*;

    localparam int H = WIDTH / 2;
    localparam logic [WIDTH:0] ERR_LIMIT = (WIDTH+1)'(1) << H;

    if (!width_ok(WIDTH)) begin : g_bad_width
        $fatal(1, "hapc_adder: WIDTH must be a non-zero multiple of 8"); // R1
    end

    logic [WIDTH-1:0] a_in;
    logic [WIDTH-1:0] b_in;
    logic [H-1:0]     low_res;
    logic             mid_cy;
    logic [H:0]       high_res;
    logic [WIDTH:0]   res_c;

    hapc_or_low #(.HALF(H), .RECOVER(RECOVER)) u_low (
        .lo_a   (a_in[H-1:0]),
        .lo_b   (b_in[H-1:0]),
        .lo_sum (low_res),
        .lo_cy  (mid_cy)
    );

    hapc_exact_high #(.HALF(H)) u_high (
        .hi_a   (a_in[WIDTH-1:H]),
        .hi_b   (b_in[WIDTH-1:H]),
        .hi_ci  (mid_cy),
        .hi_sum (high_res)
    );

    // Join the exact upper half and the approximate lower half.
    always_comb res_c = {high_res, low_res};

    if (REGISTERED) begin : g_reg
        logic [WIDTH-1:0] a_q;
        logic [WIDTH-1:0] b_q;
        logic [WIDTH:0]   sum_q;
        logic [WIDTH:0]   exact_c;

        // Operand stage.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                a_q <= '0;
                b_q <= '0;
            end else begin
                a_q <= op_a;
                b_q <= op_b;
            end
        end

        // Result stage.
        always_ff @(posedge clk) begin
            if (!rst_n) sum_q <= '0;
            else        sum_q <= res_c;
        end

        always_comb begin
            a_in = a_q;
            b_in = b_q;
            sum  = sum_q;
        end

        // Exact sum of the staged operands, used only by the checks.
        always_comb exact_c = {1'b0, a_q} + {1'b0, b_q};

        AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> sum_q == '0); // R9

        AST_HIGH_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
            sum_q[WIDTH:H] == ({1'b0, $past(a_q[WIDTH-1:H])} + {1'b0, $past(b_q[WIDTH-1:H])}
                + (H+1)'(RECOVER & $past(a_q[H-1] & b_q[H-1])))); // R3

        AST_LOW_OR: assert property (@(posedge clk) disable iff (!rst_n)
            !(RECOVER && $past(a_q[H-1] & b_q[H-1]))
            |-> sum_q[H-1:0] == $past(a_q[H-1:0] | b_q[H-1:0])); // R2

        AST_RECOVER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
            (RECOVER && $past(a_q[H-1] & b_q[H-1])) |-> (&sum_q[H-2:0])); // R6

        AST_ERR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            ((sum_q >= $past(exact_c)) ? (sum_q - $past(exact_c))
                                       : ($past(exact_c) - sum_q)) <= ERR_LIMIT); // R7
    end else begin : g_comb
        // Pass-through: no clocked stage.
        always_comb begin
            a_in = op_a;
            b_in = op_b;
            sum  = res_c;
        end
    end

endmodule

// File: tb/hapc_adder_tb.sv
`timescale 1ns/1ps
// Bench: drives one operand stream into the plain and the recovery variant
// and checks both against models computed from the requirements.
module hapc_adder_tb;

    localparam int W = 16;
    localparam int H = W / 2;
    localparam int NRAND = 1500;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [W:0]   sum_pl;
    logic [W:0]   sum_er;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;
    longint err_pl_tot = 0;
    longint err_er_tot = 0;

    always #10 clk = ~clk;

    hapc_adder #(.WIDTH(W), .RECOVER(1'b0), .REGISTERED(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .sum(sum_pl));

    hapc_adder #(.WIDTH(W), .RECOVER(1'b1), .REGISTERED(1'b1)) u_dut_er (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .sum(sum_er));

    // Result model built from R2, R3, R5, R6.
    function automatic logic [W:0] model(input logic [W-1:0] a, input logic [W-1:0] b, input bit rec);
        logic         cin;
        logic [H-1:0] lo;
        logic [H:0]   hi;
        cin = rec & a[H-1] & b[H-1];
        lo  = a[H-1:0] | b[H-1:0];
        if (cin) lo[H-2:0] = '1;
        hi  = {1'b0, a[W-1:H]} + {1'b0, b[W-1:H]} + (H+1)'(cin);
        return {hi, lo};
    endfunction

    function automatic longint abs_err(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W:0] s);
        longint ex;
        ex = longint'(a) + longint'(b);
        return (ex > longint'(s)) ? ex - longint'(s) : longint'(s) - ex;
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Apply one pair, wait through both stages, check both variants.
    task automatic run_vec(input logic [W-1:0] a, input logic [W-1:0] b, input string tag, input bit acc);
        longint ep;
        longint ee;
        @(negedge clk);
        op_a = a;
        op_b = b;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check({tag, " plain"},    sum_pl, model(a, b, 1'b0));
        check({tag, " recovery"}, sum_er, model(a, b, 1'b1));
        ep = abs_err(a, b, sum_pl);
        ee = abs_err(a, b, sum_er);
        check("R7 bound plain",    (ep <= (64'd1 << H)) ? 1 : 0, 1);
        check("R7 bound recovery", (ee <= (64'd1 << H)) ? 1 : 0, 1);
        if (acc) begin
            err_pl_tot += ep;
            err_er_tot += ee;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL R9 watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R9 reset plain", sum_pl, 0);
        check("R9 reset recovery", sum_er, 0);

        // R9 latency: the value is still 0 after one edge, updated after two.
        rst_n = 1'b1;
        op_a = 16'h1234;
        op_b = 16'h0101;
        @(posedge clk);
        @(negedge clk);
        check("R9 latency one edge", sum_pl, 0);
        @(posedge clk);
        @(negedge clk);
        check("R9 latency two edges", sum_pl, model(16'h1234, 16'h0101, 1'b0));

        run_vec(16'h0000, 16'h0000, "R2 zero", 1'b0);
        run_vec(16'hFFFF, 16'hFFFF, "R3 all ones", 1'b0);
        check("R3 all ones carry-out", sum_pl[W], 1);
        check("R5 all ones recovery", sum_er, 17'h1FFFF);
        run_vec(16'hAAAA, 16'h5555, "R2 alternating", 1'b0);
        run_vec(16'h5555, 16'h5555, "R2 same alternating", 1'b0);
        run_vec(16'h0080, 16'h0080, "R6 top-low pair", 1'b0);
        check("R6 fill recovery", sum_er, 17'h001FF);
        check("R5 no carry plain", sum_pl, 17'h00080);
        run_vec(16'h0F00, 16'h0100, "R4 cross block", 1'b0);
        check("R4 cross block value", sum_pl, 17'h01000);
        run_vec(16'hFF00, 16'h0100, "R3 carry out", 1'b0);
        check("R3 carry out value", sum_pl, 17'h10000);
        run_vec(16'h00FF, 16'h0001, "R2 low no carry", 1'b0);
        check("R2 low no carry value", sum_pl, 17'h000FF);

        for (int i = 0; i < NRAND; i++) begin
            run_vec(16'($urandom), 16'($urandom), "R3 random", 1'b1);
        end

        $display("mean abs error plain=%0.3f recovery=%0.3f",
                 real'(err_pl_tot) / NRAND, real'(err_er_tot) / NRAND);
        check("R8 recovery mean lower", (err_er_tot < err_pl_tot) ? 1 : 0, 1);

        // R9: asserting reset clears the output after one edge.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R9 reset again", sum_er, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule